// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A synthesizable behavioural model of a synchronous static RAM with a shared 32-bit data path split into four byte lanes. Every control and address input is registered on the rising clock edge. The array is read through an output register, so read data appears on the bus two rising edges after the command is presented. The storage depth is a parameter. `ADDR_W = 18` gives the full 256K-word part. The default is smaller so that elaboration stays light.

An access sequence starts with one of two address strobes. One strobe is for the processor side and only counts while the first chip enable is active. The other is for the controller side. Both load the address and clear a 2-bit wrapping burst counter. Later cycles either advance the counter or suspend on the same word. The burst order is sampled when a sequence starts and is either interleaved or linear. Writes can cover the whole word or selected byte lanes.

The output bus is split into `dq_out`, `dq_oe` and `dq_in`, and the pad-level tri-state is built outside this block. A sleep input freezes the device while the array keeps its contents.

Top module: `sync_burst_sram`

## Requirements
- R1: A read command sampled at rising edge n drives the addressed word on `dq_out`, with `dq_oe` high when `oe_n` is low, after edge n+1.
- R2: With `all_wr_n` low, an access writes all four byte lanes, whatever `byte_wr_n` and `lane_n` are.
- R3: With `all_wr_n` high and `byte_wr_n` low, only the lanes i with `lane_n[i]` low are written; lane i is `dq_in[8i+7:8i]`. With all four `lane_n` bits high, the access is a read.
- R4: With `all_wr_n` and `byte_wr_n` both high, the access is a read.
- R5: A start loads the address and clears the counter. Each later cycle with `adv_n` low adds 1 (mod 4) to the counter. The word offset is the start offset XOR the count when `lin_order` was 0 at the start, and the start offset plus the count (mod 4) when it was 1. The upper address bits are held for the whole sequence.
- R6: While selected, a cycle with no strobe and `adv_n` high accesses the same word again.
- R7: A processor-strobe start (`cpu_strb_n` low with `en1_n` low) is always a read. The processor strobe is ignored while `en1_n` is high. A controller-strobe start uses the write controls.
- R8: A strobe while the chip is not enabled (`en1_n` high, `en2` low or `en3_n` high) deselects the device. The device then makes no access until the next enabled start.
- R9: After a write, `dq_oe` stays low until a read takes place in a start or advance cycle. Suspend reads that follow a write leave the bus undriven.
- R10: A cycle with `sleep` high makes no access and deselects the device. The array contents are kept, and the bus stays undriven after sleep until a new start.
- R11: `dq_oe` is high only while `oe_n` is low.
- R12: After a synchronous reset, `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address |
| en1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| en2 | input | 1 | Chip enable 2, active high |
| en3_n | input | 1 | Chip enable 3, active low |
| cpu_strb_n | input | 1 | Processor-side address strobe, active low |
| ctl_strb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Full-word write, active low |
| byte_wr_n | input | 1 | Byte-write enable, active low |
| lane_n | input | DATA_W/8 | Per-lane write select, active low |
| oe_n | input | 1 | Output enable, active low |
| lin_order | input | 1 | Burst order: 0 interleaved, 1 linear |
| sleep | input | 1 | Sleep request, active high |
| dq_in | input | DATA_W | Write data from the bus |
| dq_out | output | DATA_W | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The assertions assume that `sleep` is raised only while the device is deselected, and they check this assumption as a property. To stay within it, the bench issues a strobe with the chip disabled before every sleep period and never raises `sleep` in its random phase. The random phase mixes enabled starts, deselects, advances and suspends with random byte-lane masks and burst orders. It first fills every word with a known value, so that every read has a defined expected result.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_START = 2'd1,
    OP_ADV   = 2'd2,
    OP_HOLD  = 2'd3
  } sbs_op_e;

  // word offset within a 4-word burst
  function automatic logic [1:0] burst_offset(input logic [1:0] first,
                                              input logic [1:0] count,
                                              input logic       linear);
    return linear ? (first + count) : (first ^ count);
  endfunction

endpackage

// File: rtl/sbs_lanes.sv
module sbs_lanes #(
  parameter int LANES = 4
) (
  input  logic             all_wr_n,
  input  logic             byte_wr_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             force_read,
  output logic [LANES-1:0] wr_mask
);

  always_comb begin
    if (force_read)
      wr_mask = '0;
    else if (!all_wr_n)
      wr_mask = '1;
    else if (!byte_wr_n)
      wr_mask = ~lane_n;
    else
      wr_mask = '0;
  end

endmodule

// File: rtl/sbs_seq.sv
module sbs_seq
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  sbs_op_e           op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              lin_order,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [1:0]        cnt_o
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      first_q;
  logic [1:0]      cnt_q;
  logic            lin_q;
  logic [1:0]      cnt_use;

  always_comb begin
    cnt_use = (op == OP_ADV) ? cnt_q + 2'd1 : cnt_q;
    if (op == OP_START)
      acc_addr = cmd_addr;
    else
      acc_addr = {hi_q, burst_offset(first_q, cnt_use, lin_q)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q    <= '0;
      first_q <= '0;
      cnt_q   <= '0;
      lin_q   <= 1'b0;
    end else if (op == OP_START) begin
      hi_q    <= cmd_addr[ADDR_W-1:2];
      first_q <= cmd_addr[1:0];
      cnt_q   <= 2'd0;
      lin_q   <= lin_order;
    end else if (op == OP_ADV) begin
      cnt_q   <= cnt_use;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        we,
  input  logic                    re,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_l;

    always_ff @(posedge clk) begin
      if (we[g])
        mem[addr] <= wdata[g*LANE_W +: LANE_W];
      if (re)
        rd_l <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_l;
  end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                en1_n,
  input  logic                en2,
  input  logic                en3_n,
  input  logic                cpu_strb_n,
  input  logic                ctl_strb_n,
  input  logic                adv_n,
  input  logic                all_wr_n,
  input  logic                byte_wr_n,
  input  logic [DATA_W/8-1:0] lane_n,
  input  logic                oe_n,
  input  logic                lin_order,
  input  logic                sleep,
  input  logic [DATA_W-1:0]   dq_in,
  output logic [DATA_W-1:0]   dq_out,
  output logic                dq_oe
);

  localparam int LANES = DATA_W / 8;

  sbs_op_e           op;
  logic              chip_en;
  logic              cpu_go;
  logic              strobe;
  logic              desel;
  logic              sel_q;
  logic              rdmode_q;
  logic [LANES-1:0]  mask;
  logic [LANES-1:0]  mask_eff;
  logic              is_rd;
  logic              rd_go;
  logic [ADDR_W-1:0] acc_addr;
  logic [1:0]        burst_cnt;

  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_mask;
  logic [DATA_W-1:0] s1_wdata;
  logic              s1_rd;
  logic              out_valid;

  always_comb begin
    chip_en = !en1_n && en2 && !en3_n;
    cpu_go  = !cpu_strb_n && !en1_n;
    strobe  = cpu_go || !ctl_strb_n;
    op      = OP_IDLE;
    desel   = 1'b0;
    if (sleep)
      desel = 1'b1;
    else if (strobe) begin
      if (chip_en) op = OP_START;
      else         desel = 1'b1;
    end else if (sel_q)
      op = adv_n ? OP_HOLD : OP_ADV;
  end

  sbs_lanes #(.LANES(LANES)) u_lanes (
    .all_wr_n  (all_wr_n),
    .byte_wr_n (byte_wr_n),
    .lane_n    (lane_n),
    .force_read(cpu_go),
    .wr_mask   (mask)
  );

  sbs_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .cmd_addr (addr),
    .lin_order(lin_order),
    .acc_addr (acc_addr),
    .cnt_o    (burst_cnt)
  );

  always_comb begin
    mask_eff = (op == OP_IDLE) ? '0 : mask;
    is_rd    = (op != OP_IDLE) && (mask == '0);
    rd_go    = is_rd && ((op == OP_START) || (op == OP_ADV) || rdmode_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= 1'b0;
      rdmode_q  <= 1'b0;
      s1_mask   <= '0;
      s1_rd     <= 1'b0;
      s1_addr   <= '0;
      out_valid <= 1'b0;
    end else begin
      if (desel)
        sel_q <= 1'b0;
      else if (op == OP_START)
        sel_q <= 1'b1;
      if (desel)
        rdmode_q <= 1'b0;
      else if (op != OP_IDLE)
        rdmode_q <= rd_go;
      s1_mask   <= mask_eff;
      s1_rd     <= rd_go;
      s1_addr   <= acc_addr;
      out_valid <= s1_rd;
    end
  end

  always_ff @(posedge clk) begin
    s1_wdata <= dq_in;
  end

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(8)) u_array (
    .clk  (clk),
    .we   (s1_mask),
    .re   (s1_rd),
    .addr (s1_addr),
    .wdata(s1_wdata),
    .rdata(dq_out)
  );

  assign dq_oe = out_valid && !oe_n;

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker
  import sbs_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             oe_n,
  input logic             sleep,
  input logic             dq_oe,
  input logic             s1_rd,
  input logic [LANES-1:0] s1_mask,
  input logic             sel_q,
  input logic             cpu_go,
  input sbs_op_e          op,
  input logic [1:0]       burst_cnt
);

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    s1_rd |=> (dq_oe == !oe_n)); // R1

  AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADV) |=> (burst_cnt == $past(burst_cnt) + 2'd1)); // R5

  AST_CPU_STROBE_READ: assert property (@(posedge clk) disable iff (rst)
    (cpu_go && op == OP_START) |=> (s1_mask == '0)); // R7

  AST_HIZ_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (s1_mask != '0) |=> !dq_oe); // R9

  AST_SLEEP_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !sel_q); // R10

  AST_SLEEP_HIZ: assert property (@(posedge clk) disable iff (rst)
    $past(sleep) |=> !dq_oe); // R10

  AST_OE_GATE: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> !oe_n); // R11

endmodule

bind sync_burst_sram sbs_checker #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .oe_n     (oe_n),
  .sleep    (sleep),
  .dq_oe    (dq_oe),
  .s1_rd    (s1_rd),
  .s1_mask  (s1_mask),
  .sel_q    (sel_q),
  .cpu_go   (cpu_go),
  .op       (op),
  .burst_cnt(burst_cnt)
);

// File: tb/sim_sync_burst_sram.sv
`timescale 1ns/1ps
module sim_sync_burst_sram;

  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          en1_n = 1'b1, en2 = 1'b0, en3_n = 1'b1;
  logic          cpu_strb_n = 1'b1, ctl_strb_n = 1'b1, adv_n = 1'b1;
  logic          all_wr_n = 1'b1, byte_wr_n = 1'b1;
  logic [3:0]    lane_n = 4'hF;
  logic          oe_n = 1'b0, lin_order = 1'b0, sleep = 1'b0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int errors = 0;
  int checks = 0;
  string cur_req = "R12";

  // bench model state
  logic [DW-1:0]   mdl [NW];
  logic            m_sel = 1'b0, m_rdm = 1'b0, m_lin = 1'b0;
  logic [AW-3:0]   m_hi = '0;
  logic [1:0]      m_off = '0, m_cnt = '0;
  logic            e1_vis = 1'b0, e2_vis = 1'b0;
  logic [DW-1:0]   e1_dat = '0, e2_dat = '0;

  always #2 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .addr(addr), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
    .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n), .adv_n(adv_n),
    .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n), .lane_n(lane_n), .oe_n(oe_n),
    .lin_order(lin_order), .sleep(sleep), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [1:0] boff(logic [1:0] s, logic [1:0] c, logic lin);
    return lin ? 2'(s + c) : (s ^ c);
  endfunction

  function automatic logic [3:0] wmask(logic gw, logic bwe, logic [3:0] bw);
    if (!gw) return 4'hF;
    if (!bwe) return ~bw;
    return 4'h0;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // evaluate the command on the pins, compare outputs, advance one cycle
  task automatic tick();
    logic chip, pgo, acc, newc, vis;
    logic [AW-1:0] a;
    logic [3:0] msk;
    logic [DW-1:0] dat;
    #1;
    chip = !en1_n && en2 && !en3_n;
    pgo  = !cpu_strb_n && !en1_n;
    acc = 1'b0; newc = 1'b0; vis = 1'b0; dat = '0; a = '0; msk = '0;
    if (sleep) begin
      m_sel = 1'b0; m_rdm = 1'b0;
    end else if (pgo || !ctl_strb_n) begin
      if (!chip) begin
        m_sel = 1'b0; m_rdm = 1'b0;
      end else begin
        m_sel = 1'b1; m_hi = addr[AW-1:2]; m_off = addr[1:0]; m_cnt = 2'd0;
        m_lin = lin_order; a = addr; acc = 1'b1; newc = 1'b1;
        msk = pgo ? 4'h0 : wmask(all_wr_n, byte_wr_n, lane_n);
      end
    end else if (m_sel) begin
      if (!adv_n) begin m_cnt = m_cnt + 2'd1; newc = 1'b1; end
      a = {m_hi, boff(m_off, m_cnt, m_lin)};
      acc = 1'b1;
      msk = wmask(all_wr_n, byte_wr_n, lane_n);
    end
    if (acc) begin
      if (msk != 4'h0) begin
        for (int i = 0; i < 4; i++)
          if (msk[i]) mdl[a][8*i +: 8] = dq_in[8*i +: 8];
        m_rdm = 1'b0;
      end else begin
        vis = newc || m_rdm;
        m_rdm = vis;
        dat = mdl[a];
      end
    end
    check(cur_req, {31'd0, dq_oe}, {31'd0, e2_vis && !oe_n});
    if (e2_vis && !oe_n) check(cur_req, dq_out, e2_dat);
    e2_vis = e1_vis; e2_dat = e1_dat;
    e1_vis = vis;    e1_dat = dat;
    @(negedge clk);
  endtask

  task automatic quiet();
    cpu_strb_n = 1'b1; ctl_strb_n = 1'b1; adv_n = 1'b1;
    all_wr_n = 1'b1; byte_wr_n = 1'b1; lane_n = 4'hF; sleep = 1'b0;
  endtask

  task automatic enable(logic on);
    en1_n = !on; en2 = on; en3_n = !on;
  endtask

  task automatic ctl_start(logic [AW-1:0] a, logic gw, logic bwe, logic [3:0] bw,
                           logic [DW-1:0] d);
    quiet(); enable(1'b1);
    addr = a; ctl_strb_n = 1'b0; all_wr_n = gw; byte_wr_n = bwe; lane_n = bw; dq_in = d;
    tick();
  endtask

  task automatic cpu_start(logic [AW-1:0] a, logic lin);
    quiet(); enable(1'b1);
    addr = a; cpu_strb_n = 1'b0; lin_order = lin; all_wr_n = 1'b0;
    tick();
  endtask

  task automatic cont(logic adv, logic gw, logic bwe, logic [3:0] bw, logic [DW-1:0] d);
    quiet(); adv_n = !adv; all_wr_n = gw; byte_wr_n = bwe; lane_n = bw; dq_in = d;
    tick();
  endtask

  task automatic deselect();
    quiet(); enable(1'b0); ctl_strb_n = 1'b0;
    tick();
  endtask

  initial begin : watchdog
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1;
    check("R12", {31'd0, dq_oe}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // fill every word with a full-word write (R2: byte controls must not matter)
    cur_req = "R2";
    for (int i = 0; i < NW; i++)
      ctl_start(AW'(i), 1'b0, 1'b1, 4'h0, 32'hA500_0000 | i);

    // interleaved and linear bursts via the processor strobe (R1, R5, R7)
    cur_req = "R5";
    cpu_start(6'd5, 1'b0);
    for (int k = 0; k < 5; k++) cont(1'b1, 1'b1, 1'b1, 4'hF, '0);
    cpu_start(6'd6, 1'b1);
    for (int k = 0; k < 5; k++) cont(1'b1, 1'b1, 1'b1, 4'hF, '0);
    cur_req = "R1";
    cont(1'b0, 1'b1, 1'b1, 4'hF, '0);
    cont(1'b0, 1'b1, 1'b1, 4'hF, '0);

    // byte-lane writes and their read-back (R3, R4)
    cur_req = "R3";
    ctl_start(6'd10, 1'b1, 1'b0, 4'b1010, 32'h1122_3344);
    ctl_start(6'd10, 1'b1, 1'b0, 4'hF, 32'hDEAD_BEEF);
    cont(1'b0, 1'b1, 1'b0, 4'hF, '0);
    cur_req = "R4";
    ctl_start(6'd10, 1'b1, 1'b1, 4'h0, 32'hFFFF_FFFF);
    cont(1'b0, 1'b1, 1'b1, 4'h0, '0);

    // processor strobe during writes is a read (R7); ignored with en1_n high
    cur_req = "R7";
    quiet(); enable(1'b1); addr = 6'd12; cpu_strb_n = 1'b0; all_wr_n = 1'b0;
    dq_in = 32'h0BAD_0BAD; tick();
    quiet(); en1_n = 1'b1; addr = 6'd40; cpu_strb_n = 1'b0; tick();
    cont(1'b0, 1'b1, 1'b1, 4'hF, '0);

    // write then suspend reads stay undriven until an advance (R9, R6)
    cur_req = "R9";
    ctl_start(6'd20, 1'b0, 1'b1, 4'hF, 32'h5555_AAAA);
    cont(1'b0, 1'b1, 1'b1, 4'hF, '0);
    cont(1'b0, 1'b1, 1'b1, 4'hF, '0);
    cur_req = "R6";
    cont(1'b1, 1'b1, 1'b1, 4'hF, '0);
    cont(1'b0, 1'b1, 1'b1, 4'hF, '0);
    cont(1'b0, 1'b1, 1'b1, 4'hF, '0);

    // deselect stops access (R8)
    cur_req = "R8";
    deselect();
    cont(1'b1, 1'b0, 1'b1, 4'hF, 32'h7777_7777);
    cont(1'b0, 1'b1, 1'b1, 4'hF, '0);
    cont(1'b0, 1'b1, 1'b1, 4'hF, '0);

    // sleep: no access, contents kept, undriven afterwards (R10)
    cur_req = "R10";
    cpu_start(6'd33, 1'b0);
    deselect();
    for (int k = 0; k < 3; k++) begin
      quiet(); sleep = 1'b1; enable(1'b1); ctl_strb_n = 1'b0; all_wr_n = 1'b0;
      addr = 6'd33; dq_in = 32'hFEED_FACE; tick();
    end
    cont(1'b0, 1'b1, 1'b1, 4'hF, '0);
    cont(1'b0, 1'b1, 1'b1, 4'hF, '0);
    cpu_start(6'd33, 1'b0);
    cont(1'b0, 1'b1, 1'b1, 4'hF, '0);
    cont(1'b0, 1'b1, 1'b1, 4'hF, '0);

    // output enable gates the bus (R11)
    cur_req = "R11";
    cpu_start(6'd2, 1'b1);
    cont(1'b0, 1'b1, 1'b1, 4'hF, '0);
    oe_n = 1'b1;
    cont(1'b0, 1'b1, 1'b1, 4'hF, '0);
    cont(1'b0, 1'b1, 1'b1, 4'hF, '0);
    oe_n = 1'b0;
    cont(1'b0, 1'b1, 1'b1, 4'hF, '0);
    cont(1'b0, 1'b1, 1'b1, 4'hF, '0);

    // random mix (R1..R9)
    cur_req = "R5";
    for (int n = 0; n < 3000; n++) begin
      int pick;
      pick = int'($urandom_range(0, 15));
      quiet();
      addr      = AW'($urandom);
      dq_in     = $urandom;
      lin_order = 1'($urandom);
      oe_n      = ($urandom_range(0, 7) == 0);
      all_wr_n  = ($urandom_range(0, 3) != 0);
      byte_wr_n = 1'($urandom);
      lane_n    = 4'($urandom);
      adv_n     = 1'($urandom);
      enable($urandom_range(0, 7) != 0);
      if (pick < 2)      cpu_strb_n = 1'b0;
      else if (pick < 4) ctl_strb_n = 1'b0;
      else if (pick < 5) begin cpu_strb_n = 1'b0; en1_n = 1'b1; end
      tick();
    end
    oe_n = 1'b0;
    quiet(); tick(); tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule